// File: doc/BRIEF.md
# Line drive activity monitor

This block sits beside one channel of a bipolar line transmitter. It watches a pair of monitor rails, one for positive pulses and one for negative pulses, and reports on an active-low status output whether the line is carrying pulse activity. The status is low while pulses keep arriving. It goes high once the line has been silent for a fixed number of transmit-clock periods. Both rails pass through a two-stage synchronizer. Any change on either rail between two consecutive clock samples counts as a transition.

The monitor rails come from one of two places. They can come from external monitor pins. When self-monitoring is selected, they come from the channel's own driven line outputs. The block also decides whether the transmitter drives the line. In hardware mode the enable pin alone decides. In host mode a host control bit must be set and the enable pin must be high. When the transmitter is off, both line outputs are released to high impedance. The monitor is only a diagnostic. It never alters transmit data, and it keeps running whether or not the transmitter is enabled.

Top module: `line_activity_mon`

## Requirements
- R1: After reset, `activity_n` is 1 and the silence counter is zero. With idle rails, `activity_n` stays 1.
- R2: A change on either selected monitor rail is captured through two synchronizer flops. Counting from the clock edge after the change, `activity_n` reads 0 after the third rising edge. Each such change clears the silence counter.
- R3: While the gap between successive transitions is 128 clock periods or less, `activity_n` stays 0 without interruption.
- R4: When no transition is detected for 128 clock periods, `activity_n` goes to 1. This happens on the 131st rising edge after the last rail change, which is within the allowed 96 to 160 window.
- R5: The silence counter saturates at 128. `activity_n` then stays 1 for any length of silence, and it returns to 0 as described in R2 on the next transition.
- R6: A change on both rails at the same sample is treated as a single transition, with the same timing as a change on one rail.
- R7: With `self_mon` = 1, the monitor rails are the channel's driven line rails (`tx_p_in`, `tx_n_in` while the transmitter is on). Changes on `ext_mon_p`/`ext_mon_n` have no effect on `activity_n`.
- R8: With `self_mon` = 0, the monitor rails are `ext_mon_p`/`ext_mon_n`. Changes on `tx_p_in`/`tx_n_in` have no effect on `activity_n`.
- R9: With `self_mon` = 1 and the transmitter off, the looped-back rails read as 0. Changes on `tx_p_in`/`tx_n_in` leave `activity_n` at 1.
- R10: In hardware mode (`host_mode` = 0), `line_oe` equals `en_pin`, regardless of `host_en`.
- R11: In host mode (`host_mode` = 1), `line_oe` is 1 only when both `host_en` and `en_pin` are 1.
- R12: With `line_oe` = 1, `line_p`/`line_n` follow `tx_p_in`/`tx_n_in` in the same cycle. With `line_oe` = 0, both line outputs are high impedance.
- R13: With `self_mon` = 0, the monitor operates as in R2 to R4 while the transmitter is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_mon_p | input | 1 | External positive monitor rail |
| ext_mon_n | input | 1 | External negative monitor rail |
| self_mon | input | 1 | 1 selects the channel's own line rails for monitoring |
| tx_p_in | input | 1 | Positive transmit rail from the encoder |
| tx_n_in | input | 1 | Negative transmit rail from the encoder |
| en_pin | input | 1 | Transmitter enable pin |
| host_en | input | 1 | Host control bit enabling this channel's transmitter |
| host_mode | input | 1 | 0 hardware control, 1 host control |
| line_p | output | 1 | Positive line output, high impedance when off |
| line_n | output | 1 | Negative line output, high impedance when off |
| line_oe | output | 1 | 1 while the transmitter drives the line |
| activity_n | output | 1 | 0 while activity is seen, 1 after silence |

## Verification
The bench uses the default parameters: a two-stage synchronizer, an 8-bit counter and a limit of 128. With these values every gap from 1 to 160 cycles can be swept, so the exact edge where a gap turns from "status stays low" into "status rises" (a gap of 128 against 129) and the saturated state after long silence are both exercised. The same cycle-exact model is applied to each source selection, to each rail and to both rails changing together. The full eight-entry truth table of the enable controls is also covered.

// File: rtl/line_mon_pkg.sv
package line_mon_pkg;

    typedef enum logic {
        CTRL_HW   = 1'b0,
        CTRL_HOST = 1'b1
    } ctrl_mode_e;

    localparam int RAIL_W = 2;

endpackage

// File: rtl/line_mon_sync.sv
module line_mon_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] synced
);

    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = raw;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign synced = stg_q[STAGES-1];

endmodule

// File: rtl/line_mon_timer.sv
module line_mon_timer #(
    parameter int W     = 2,
    parameter int CNT_W = 8,
    parameter int LIMIT = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rail,
    output logic         idle
);

    localparam logic [CNT_W-1:0] LIM     = CNT_W'(LIMIT);
    localparam logic [CNT_W-1:0] LIM_M1  = CNT_W'(LIMIT - 1);

    typedef struct packed {
        logic [W-1:0]     prev;
        logic [CNT_W-1:0] cnt;
        logic             idle;
    } tmr_t;

    tmr_t st_d, st_q;
    logic hit;

    always_comb begin
        st_d      = st_q;
        hit       = |(rail ^ st_q.prev);
        st_d.prev = rail;
        if (hit) begin
            st_d.cnt  = '0;
            st_d.idle = 1'b0;
        end else if (st_q.cnt != LIM) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
            if (st_q.cnt == LIM_M1) st_d.idle = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prev <= '0;
            st_q.cnt  <= '0;
            st_q.idle <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign idle = st_q.idle;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LIM); // R5
    AST_FALL_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (!st_q.idle && st_q.cnt == '0)); // R2
    AST_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.idle && !hit && st_q.cnt != LIM_M1) |=> !st_q.idle); // R3
    AST_RISE_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && st_q.cnt == LIM_M1) |=> st_q.idle); // R4
    AST_SAT_STAY: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && st_q.cnt == LIM) |=> (st_q.idle && st_q.cnt == LIM)); // R5

endmodule

// File: rtl/line_mon_txgate.sv
module line_mon_txgate
    import line_mon_pkg::*;
(
    input  logic       host_mode,
    input  logic       en_pin,
    input  logic       host_en,
    input  logic       self_mon,
    input  logic [1:0] tx_rail,
    input  logic [1:0] ext_rail,
    output logic       oe,
    output logic [1:0] mon_rail
);

    ctrl_mode_e mode;
    logic [1:0] loop_rail;

    always_comb begin
        mode = ctrl_mode_e'(host_mode);
        case (mode)
            CTRL_HOST: oe = en_pin & host_en;
            default:   oe = en_pin;
        endcase
        loop_rail = oe ? tx_rail : 2'b00;
        mon_rail  = self_mon ? loop_rail : ext_rail;
    end

endmodule

// File: rtl/line_activity_mon.sv
module line_activity_mon #(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 8,
    parameter int LIMIT       = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_mon_p,
    input  logic ext_mon_n,
    input  logic self_mon,
    input  logic tx_p_in,
    input  logic tx_n_in,
    input  logic en_pin,
    input  logic host_en,
    input  logic host_mode,
    output logic line_p,
    output logic line_n,
    output logic line_oe,
    output logic activity_n
);

    import line_mon_pkg::*;

    logic [RAIL_W-1:0] mon_raw;
    logic [RAIL_W-1:0] mon_sync;
    logic              oe;
    logic              idle;

    line_mon_txgate u_gate (
        .host_mode (host_mode),
        .en_pin    (en_pin),
        .host_en   (host_en),
        .self_mon  (self_mon),
        .tx_rail   ({tx_n_in, tx_p_in}),
        .ext_rail  ({ext_mon_n, ext_mon_p}),
        .oe        (oe),
        .mon_rail  (mon_raw)
    );

    line_mon_sync #(.W(RAIL_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (mon_raw),
        .synced (mon_sync)
    );

    line_mon_timer #(.W(RAIL_W), .CNT_W(CNT_W), .LIMIT(LIMIT)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .rail  (mon_sync),
        .idle  (idle)
    );

    assign line_oe    = oe;
    assign line_p     = oe ? tx_p_in : 1'bz;
    assign line_n     = oe ? tx_n_in : 1'bz;
    assign activity_n = idle;

    AST_HW_FOLLOWS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        !host_mode |-> (line_oe == en_pin)); // R10
    AST_HOST_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (host_mode && !host_en) |-> !line_oe); // R11
    AST_LOOP_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (self_mon && !line_oe) |-> (mon_raw == '0)); // R9

endmodule

// File: tb/line_activity_mon_test.sv
module line_activity_mon_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_mon_p = 0, ext_mon_n = 0, self_mon = 0;
    logic tx_p_in = 0, tx_n_in = 0;
    logic en_pin = 0, host_en = 0, host_mode = 0;
    wire  line_p, line_n, line_oe, activity_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    line_activity_mon uut (
        .clk(clk), .rst_n(rst_n),
        .ext_mon_p(ext_mon_p), .ext_mon_n(ext_mon_n), .self_mon(self_mon),
        .tx_p_in(tx_p_in), .tx_n_in(tx_n_in),
        .en_pin(en_pin), .host_en(host_en), .host_mode(host_mode),
        .line_p(line_p), .line_n(line_n), .line_oe(line_oe),
        .activity_n(activity_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic flip(input int src, input logic [1:0] mask);
        if (src == 0) begin
            ext_mon_p = ext_mon_p ^ mask[0];
            ext_mon_n = ext_mon_n ^ mask[1];
        end else begin
            tx_p_in = tx_p_in ^ mask[0];
            tx_n_in = tx_n_in ^ mask[1];
        end
    endtask

    // Two changes g cycles apart; model: low iff (3<=n<131) or (g+3<=n<g+131)
    task automatic run_gap(input int src, input logic [1:0] mask, input int g,
                           input bit seen, input string req);
        bit exp_idle;
        repeat (135) @(negedge clk);
        chk(activity_n === 1'b1, "R5", int'(activity_n), 1);
        flip(src, mask);
        for (int n = 1; n <= g + 140; n++) begin
            @(negedge clk);
            exp_idle = !(seen && (((n >= 3) && (n < 131)) ||
                                  ((n >= g + 3) && (n < g + 131))));
            chk(activity_n === exp_idle, req, int'(activity_n), int'(exp_idle));
            if (n == g) flip(src, mask);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(activity_n === 1'b1, "R1", int'(activity_n), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(activity_n === 1'b1, "R1", int'(activity_n), 1);
        repeat (200) @(negedge clk);
        chk(activity_n === 1'b1, "R1", int'(activity_n), 1);

        // Enable truth table, hardware and host modes
        for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            host_mode = c[0]; en_pin = c[1]; host_en = c[2];
            tx_p_in = c[3]; tx_n_in = ~c[3];
            #1;
            if (c[0] == 1'b0)
                chk(line_oe === c[1], "R10", int'(line_oe), int'(c[1]));
            else
                chk(line_oe === (c[1] & c[2]), "R11", int'(line_oe), int'(c[1] & c[2]));
            if (line_oe === 1'b1) begin
                chk(line_p === c[3], "R12", int'(line_p), int'(c[3]));
                chk(line_n === ~c[3], "R12", int'(line_n), int'(~c[3]));
            end
        end
        @(negedge clk);
        tx_p_in = 0; tx_n_in = 0; host_mode = 0; host_en = 0; en_pin = 0;

        // Transmitter off, external monitoring: full gap sweep on positive rail
        for (int g = 1; g <= 160; g++) run_gap(0, 2'b01, g, 1'b1, (g <= 128) ? "R3" : "R4");
        // Negative rail around the boundary
        for (int g = 124; g <= 134; g++) run_gap(0, 2'b10, g, 1'b1, "R2");
        // Both rails together
        for (int g = 1; g <= 6; g++) run_gap(0, 2'b11, g, 1'b1, "R6");
        for (int g = 126; g <= 131; g++) run_gap(0, 2'b11, g, 1'b1, "R6");
        // Long silence then return
        run_gap(0, 2'b01, 400, 1'b1, "R5");
        // Transmitter off, ext monitoring still running
        run_gap(0, 2'b01, 50, 1'b1, "R13");
        // External source selected: tx rails ignored
        en_pin = 1;
        run_gap(1, 2'b01, 50, 1'b0, "R8");
        run_gap(1, 2'b11, 200, 1'b0, "R8");
        // Self monitoring with transmitter on
        self_mon = 1;
        run_gap(1, 2'b01, 60, 1'b1, "R7");
        run_gap(1, 2'b10, 129, 1'b1, "R7");
        run_gap(0, 2'b11, 40, 1'b0, "R7");
        // Self monitoring with transmitter off (hw off, and host bit clear)
        en_pin = 0;
        run_gap(1, 2'b01, 40, 1'b0, "R9");
        en_pin = 1; host_mode = 1; host_en = 0;
        run_gap(1, 2'b11, 40, 1'b0, "R9");
        host_en = 1;
        run_gap(1, 2'b01, 20, 1'b1, "R7");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule